// File: doc/BRIEF.md
# Sector Table Run Coalescer

This block turns a request for one media block into a short series of multi-sector storage transfers. It forms a block index from track, head and block-select. It uses that index to read the block's byte offset inside a disk image from an offset table. From the offset and the sector size it works out which 512-byte storage sectors the block covers. It then walks a second table that maps image sectors to physical storage sectors, and it merges entries that are physically consecutive into a single burst. When the walk ends it raises block-ready with a valid or invalid flag.

The block keeps up to four disk slots, each holding a pair of table bases, and one current slot. A pulse moves the current slot to the next slot that holds a disk, wrapping around. Both tables sit in a memory with a one-cycle synchronous read port and are stored big-endian. The storage device is a request/done handshake with an error flag. The sub-sector start offset is output so a later sector sequencer can locate sector data inside the fetched buffer.

Top module: `sector_run_merger`

## Requirements
- R1: After reset, blk_ready, blk_valid, busy, tbl_rd_en and sto_req are 0, cur_disk is 0, and every slot is empty.
- R2: The block index is (track << 2) | (head << 1) | start_blk. The first table read of an accepted request is at offset-table base + index × 4.
- R3: A request made while the current slot is empty completes one cycle later with blk_ready=1 and blk_valid=0. It makes no table read and no storage request.
- R4: An offset word equal to 0xFFFFFFFF completes the request with blk_ready=1 and blk_valid=0, with no storage request.
- R5: Table words are stored big-endian (most significant byte at the lowest address, i.e. in bits 7:0 of the read word). The block reverses the byte order of every word it reads.
- R6: The block length is (sec_size+1) × 85 bytes. sub_offset = start mod 512. The sector count is (end/512 − start/512) + 1, where end = start + length − 1. Entry i is read at sector-table base + (start/512 + i) × 4, so a request makes exactly 1 + count table reads.
- R7: Entries are merged while each one equals the previous one plus 1. A burst is issued when the chain breaks, and again after the last entry. Each burst is a one-cycle sto_req with a non-zero count. Its buffer address starts at req_buf_addr and advances by count × 512 after each burst.
- R8: A storage completion with sto_err set stops all remaining bursts and reports blk_ready=1, blk_valid=0.
- R9: After the final burst completes without error, the block reports blk_ready=1 and blk_valid=1. blk_valid is never 1 while blk_ready is 0.
- R10: blk_ready (and blk_valid) drop to 0 in the cycle after a request is accepted for a slot that holds a disk.
- R11: A slot written with cfg_present=1 keeps only the low 29 bits of both table bases. A slot written with cfg_present=0 is empty.
- R12: A next_disk pulse moves cur_disk to the first later slot, modulo 4, that holds a disk. If no other slot holds one, cur_disk is unchanged. A request accepted in the same cycle as next_disk uses the slot that was current before the pulse.
- R13: sto_write follows the req_write of the request being served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one disk slot |
| cfg_slot | input | 2 | Slot written |
| cfg_present | input | 1 | 1: store bases, 0: mark slot empty |
| cfg_blk_base | input | 32 | Offset-table base address |
| cfg_sec_base | input | 32 | Sector-table base address |
| next_disk | input | 1 | Advance to the next slot holding a disk |
| req_valid | input | 1 | Start a block request (taken when not busy) |
| req_write | input | 1 | 1: storage writes, 0: storage reads |
| req_track | input | 12 | Track number |
| req_head | input | 1 | Head select |
| req_start_blk | input | 1 | Block select within the track |
| req_sec_size | input | 8 | Sector size minus one, in bytes |
| req_buf_addr | input | 32 | Buffer address of the first burst |
| busy | output | 1 | Request in progress |
| blk_ready | output | 1 | Last request finished |
| blk_valid | output | 1 | Last request finished without fault |
| sub_offset | output | 9 | Block start offset within its first sector |
| cur_disk | output | 2 | Current disk slot |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_addr | output | 32 | Table byte address |
| tbl_rdata | input | 32 | Table word, valid the cycle after the strobe |
| sto_req | output | 1 | One-cycle storage burst request |
| sto_write | output | 1 | Burst direction |
| sto_lba | output | 32 | First physical sector of the burst |
| sto_count | output | 16 | Sectors in the burst |
| sto_buf | output | 32 | Buffer address of the burst |
| sto_done | input | 1 | Burst finished |
| sto_err | input | 1 | Burst failed (with sto_done) |

## Verification
A slot change and a request acceptance can land in the same cycle. The block must snapshot the table bases of the slot that was current before the change. The bench raises next_disk and req_valid together while the two present slots hold different offset-table bases. It then judges the outcome from the address of the first table read and from cur_disk after the request. A second overlap comes from a chain break on the last entry: the block must issue the broken run and then a final one-sector burst. Vectors whose last entry stands alone check this.

// File: rtl/srm_pkg.sv
// Shared constants, state encoding and helpers for the sector run coalescer.
// Assumes 512-byte storage sectors and 85 data sectors per media block.
package srm_pkg;
    localparam int          SECT_SH     = 9;
    localparam int          BLK_SECTORS = 85;
    localparam logic [31:0] ABSENT      = 32'hFFFF_FFFF;
    localparam logic [31:0] ADDR_MASK   = 32'h1FFF_FFFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OFS_RD, ST_OFS_USE, ST_ENT_RD, ST_ENT_USE, ST_ISSUE, ST_WAIT
    } st_t;

    // Reverse byte order of a big-endian table word.
    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/srm_slot_bank.sv
// Holds the table base pairs of SLOTS disk slots and the current slot.
// Empty slots hold ABSENT. Assumes SLOTS is a power of two.
module srm_slot_bank #(
    parameter int SLOTS = 4,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_slot,
    input  logic          cfg_present,
    input  logic [31:0]   cfg_blk_base,
    input  logic [31:0]   cfg_sec_base,
    input  logic          next_disk,
    output logic [SW-1:0] cur,
    output logic [31:0]   cur_blk_base,
    output logic [31:0]   cur_sec_base,
    output logic          cur_present
);
    import srm_pkg::*;

    logic [31:0]   blk_base [SLOTS];
    logic [31:0]   sec_base [SLOTS];
    logic [SW-1:0] nxt;

    // Find the next slot after cur that holds a disk, wrapping around.
    always_comb begin
        logic found;
        logic [SW-1:0] cand;
        nxt   = cur;
        found = 1'b0;
        for (int i = 1; i <= SLOTS; i++) begin
            cand = SW'((int'(cur) + i) % SLOTS);
            if (!found && blk_base[cand] != ABSENT) begin
                nxt   = cand;
                found = 1'b1;
            end
        end
    end

    // Slot storage: masked bases when present, ABSENT when cleared.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blk_base[g] <= ABSENT;
                sec_base[g] <= ABSENT;
            end else if (cfg_we && cfg_slot == SW'(g)) begin
                blk_base[g] <= cfg_present ? (cfg_blk_base & ADDR_MASK) : ABSENT;
                sec_base[g] <= cfg_present ? (cfg_sec_base & ADDR_MASK) : ABSENT;
            end
        end
    end

    // Current slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)         cur <= '0;
        else if (next_disk) cur <= nxt;
    end

    assign cur_blk_base = blk_base[cur];
    assign cur_sec_base = sec_base[cur];
    assign cur_present  = (blk_base[cur] != ABSENT);
endmodule

// File: rtl/srm_span.sv
// Works out the storage sectors covered by one media block from its
// unaligned byte offset and the sector size. Purely combinational.
module srm_span #(
    parameter int CNT_W = 16
) (
    input  logic [31:0]      start_ofs,
    input  logic [7:0]       sec_size,
    output logic [8:0]       sub_off,
    output logic [31:0]      first_sec,
    output logic [CNT_W-1:0] nsec
);
    import srm_pkg::*;

    logic [31:0] blk_len;
    logic [31:0] last_byte;

    // Block length, last byte, and first/last sector numbers.
    always_comb begin
        blk_len   = (32'(sec_size) + 32'd1) * 32'(BLK_SECTORS);
        last_byte = start_ofs + blk_len - 32'd1;
        first_sec = start_ofs >> SECT_SH;
        sub_off   = start_ofs[SECT_SH-1:0];
        nsec      = CNT_W'((last_byte >> SECT_SH) - first_sec + 32'd1);
    end
endmodule

// File: rtl/sector_run_merger.sv
// Top: looks up a block's offset, walks the sector table and issues merged
// storage bursts. Table reads return data one cycle after tbl_rd_en.
// Assumes one storage burst is outstanding at a time.
module sector_run_merger #(
    parameter int SLOTS   = 4,
    parameter int TRACK_W = 12,
    parameter int CNT_W   = 16,
    localparam int SW    = $clog2(SLOTS),
    localparam int IDX_W = TRACK_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SW-1:0]      cfg_slot,
    input  logic               cfg_present,
    input  logic [31:0]        cfg_blk_base,
    input  logic [31:0]        cfg_sec_base,
    input  logic               next_disk,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [TRACK_W-1:0] req_track,
    input  logic               req_head,
    input  logic               req_start_blk,
    input  logic [7:0]         req_sec_size,
    input  logic [31:0]        req_buf_addr,
    output logic               busy,
    output logic               blk_ready,
    output logic               blk_valid,
    output logic [8:0]         sub_offset,
    output logic [SW-1:0]      cur_disk,
    output logic               tbl_rd_en,
    output logic [31:0]        tbl_addr,
    input  logic [31:0]        tbl_rdata,
    output logic               sto_req,
    output logic               sto_write,
    output logic [31:0]        sto_lba,
    output logic [CNT_W-1:0]   sto_count,
    output logic [31:0]        sto_buf,
    input  logic               sto_done,
    input  logic               sto_err
);
    import srm_pkg::*;

    st_t              st;
    logic [31:0]      cur_blk_base, cur_sec_base, l_blk_base, l_sec_base;
    logic             cur_present;
    logic [IDX_W-1:0] l_idx;
    logic [7:0]       l_size;
    logic             l_write;
    logic [31:0]      cur_buf, first_sec, run_lba, hold_e, word;
    logic [CNT_W-1:0] nsec, ent_i, run_cnt;
    logic             carry, ent_last;
    logic [8:0]       sp_sub;
    logic [31:0]      sp_first;
    logic [CNT_W-1:0] sp_nsec;

    srm_slot_bank #(.SLOTS(SLOTS)) u_slots (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_present(cfg_present), .cfg_blk_base(cfg_blk_base),
        .cfg_sec_base(cfg_sec_base), .next_disk(next_disk), .cur(cur_disk),
        .cur_blk_base(cur_blk_base), .cur_sec_base(cur_sec_base),
        .cur_present(cur_present)
    );

    assign word = swap32(tbl_rdata);

    srm_span #(.CNT_W(CNT_W)) u_span (
        .start_ofs(word), .sec_size(l_size),
        .sub_off(sp_sub), .first_sec(sp_first), .nsec(sp_nsec)
    );

    assign ent_last = (ent_i == nsec - CNT_W'(1));

    // Table port and storage request drive from the current state.
    always_comb begin
        tbl_rd_en = (st == ST_OFS_RD) || (st == ST_ENT_RD);
        tbl_addr  = (st == ST_OFS_RD) ? l_blk_base + (32'(l_idx) << 2)
                                      : l_sec_base + ((first_sec + 32'(ent_i)) << 2);
    end
    assign sto_req   = (st == ST_ISSUE);
    assign sto_write = l_write;
    assign sto_lba   = run_lba;
    assign sto_count = run_cnt;
    assign sto_buf   = cur_buf;
    assign busy      = (st != ST_IDLE);

    // Request sequencer: offset lookup, entry walk, burst issue, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            blk_ready <= 1'b0;  blk_valid <= 1'b0;  sub_offset <= '0;
            l_blk_base <= '0;   l_sec_base <= '0;   l_idx <= '0;
            l_size <= '0;       l_write <= 1'b0;    cur_buf <= '0;
            first_sec <= '0;    nsec <= '0;         ent_i <= '0;
            run_lba <= '0;      run_cnt <= '0;      hold_e <= '0;
            carry <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    l_blk_base <= cur_blk_base;
                    l_sec_base <= cur_sec_base;
                    l_idx      <= {req_track, req_head, req_start_blk};
                    l_size     <= req_sec_size;
                    l_write    <= req_write;
                    cur_buf    <= req_buf_addr;
                    blk_valid  <= 1'b0;
                    blk_ready  <= !cur_present;
                    if (cur_present) st <= ST_OFS_RD;
                end
                ST_OFS_RD: st <= ST_OFS_USE;
                ST_OFS_USE: if (word == ABSENT) begin
                    blk_ready <= 1'b1;
                    st        <= ST_IDLE;
                end else begin
                    sub_offset <= sp_sub;
                    first_sec  <= sp_first;
                    nsec       <= sp_nsec;
                    ent_i      <= '0;
                    carry      <= 1'b0;
                    st         <= ST_ENT_RD;
                end
                ST_ENT_RD: st <= ST_ENT_USE;
                ST_ENT_USE: if (ent_i != '0 && word != run_lba + 32'(run_cnt)) begin
                    hold_e <= word;
                    carry  <= 1'b1;
                    st     <= ST_ISSUE;
                end else begin
                    run_lba <= (ent_i == '0) ? word : run_lba;
                    run_cnt <= (ent_i == '0) ? CNT_W'(1) : run_cnt + CNT_W'(1);
                    if (ent_last) st <= ST_ISSUE;
                    else begin
                        ent_i <= ent_i + CNT_W'(1);
                        st    <= ST_ENT_RD;
                    end
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: if (sto_done) begin
                    if (sto_err) begin
                        blk_ready <= 1'b1;
                        st        <= ST_IDLE;
                    end else begin
                        cur_buf <= cur_buf + (32'(run_cnt) << SECT_SH);
                        if (carry) begin
                            carry   <= 1'b0;
                            run_lba <= hold_e;
                            run_cnt <= CNT_W'(1);
                            if (ent_last) st <= ST_ISSUE;
                            else begin
                                ent_i <= ent_i + CNT_W'(1);
                                st    <= ST_ENT_RD;
                            end
                        end else begin
                            blk_ready <= 1'b1;
                            blk_valid <= 1'b1;
                            st        <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srm_checker.sv
// Temporal checks on the sector run coalescer, bound to the top module.
module srm_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         busy,
    input logic         cur_present,
    input srm_pkg::st_t st,
    input logic         blk_ready,
    input logic         blk_valid,
    input logic         sto_req,
    input logic [15:0]  sto_count,
    input logic         sto_done,
    input logic         sto_err
);
    import srm_pkg::*;

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && cur_present) |=> !blk_ready);            // R10
    AST_EMPTY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !cur_present) |=> (blk_ready && !blk_valid && !busy)); // R3
    AST_VALID_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |-> blk_ready);                                       // R9
    AST_BURST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sto_req |=> !sto_req);                                          // R7
    AST_BURST_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sto_req |-> (sto_count != 16'd0));                              // R7
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && sto_done && sto_err) |=> (blk_ready && !blk_valid && !sto_req)); // R8
endmodule

bind sector_run_merger srm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
    .cur_present(cur_present), .st(st), .blk_ready(blk_ready),
    .blk_valid(blk_valid), .sto_req(sto_req), .sto_count(sto_count),
    .sto_done(sto_done), .sto_err(sto_err)
);

// File: tb/sim_sector_run_merger.sv
module sim_sector_run_merger;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 0, cfg_present = 0, next_disk = 0;
    logic [1:0]  cfg_slot = 0;
    logic [31:0] cfg_blk_base = 0, cfg_sec_base = 0;
    logic        req_valid = 0, req_write = 0, req_head = 0, req_start_blk = 0;
    logic [11:0] req_track = 0;
    logic [7:0]  req_sec_size = 0;
    logic [31:0] req_buf_addr = 32'h0008_0000;
    logic        busy, blk_ready, blk_valid, tbl_rd_en, sto_req, sto_write;
    logic [8:0]  sub_offset;
    logic [1:0]  cur_disk;
    logic [31:0] tbl_addr, tbl_rdata = 0, sto_lba, sto_buf;
    logic [15:0] sto_count;
    logic        sto_done = 0, sto_err = 0;

    int checks = 0, errors = 0;

    sector_run_merger u0 (.*);

    always #2.5 clk = ~clk;

    // Models: table memory (one-cycle read) and storage (done after two cycles).
    logic [31:0] mem [2048];
    int          nb = 0, ntr = 0, dly = 0, err_at = -1;
    logic [31:0] first_taddr = 0;
    logic [31:0] lg_lba [64];
    logic [31:0] lg_buf [64];
    int          lg_cnt [64];
    logic        lg_wr  [64];
    always @(negedge clk) begin
        if (req_valid && !busy) begin nb = 0; ntr = 0; end
        if (tbl_rd_en) begin
            if (ntr == 0) first_taddr = tbl_addr;
            tbl_rdata = mem[tbl_addr[12:2]];
            ntr++;
        end
        if (sto_done) begin sto_done = 0; sto_err = 0; end
        if (sto_req) begin
            if (nb < 64) begin
                lg_lba[nb] = sto_lba; lg_buf[nb] = sto_buf;
                lg_cnt[nb] = int'(sto_count); lg_wr[nb] = sto_write;
            end
            nb++;
            dly = 2;
        end else if (dly > 0) begin
            dly--;
            if (dly == 0) begin sto_done = 1; sto_err = (nb - 1 == err_at); end
        end
    end

    function automatic logic [31:0] be(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] ent_val(input int j, input int mode);
        case (mode)
            0: return 32'(1000 + j);
            1: return 32'(1000 + 2 * j);
            default: return 32'(1000 + j + 10 * (j / 3));
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg(input int slot, input bit pres, input logic [31:0] bb, input logic [31:0] sb);
        @(negedge clk);
        cfg_we = 1; cfg_slot = 2'(slot); cfg_present = pres; cfg_blk_base = bb; cfg_sec_base = sb;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic pulse_next();
        @(negedge clk); next_disk = 1;
        @(negedge clk); next_disk = 0;
    endtask

    // Issue one request; optionally with next_disk in the same cycle.
    task automatic do_req(input int trk, input bit hd, input bit sb, input int size,
                          input bit wr, input bit with_next, output bit timed_out);
        @(negedge clk);
        req_track = 12'(trk); req_head = hd; req_start_blk = sb;
        req_sec_size = 8'(size); req_write = wr; req_valid = 1; next_disk = with_next;
        @(negedge clk);
        req_valid = 0; next_disk = 0;
        timed_out = 0;
        for (int t = 0; t < 5000 && !blk_ready; t++) @(negedge clk);
        if (!blk_ready) begin
            timed_out = 1;
            check(0, "R9", "request timeout", 0, 1);
        end
    endtask

    // start, size, mode, track, head, start_blk
    localparam logic [51:0] VEC [6] = '{
        {32'd0,    8'd231, 2'd0, 8'd3,  1'b0, 1'b1},
        {32'd300,  8'd191, 2'd1, 8'd10, 1'b1, 1'b0},
        {32'd1000, 8'd0,   2'd2, 8'd17, 1'b1, 1'b1},
        {32'd511,  8'd0,   2'd1, 8'd25, 1'b0, 1'b0},
        {32'd2047, 8'd99,  2'd2, 8'd40, 1'b1, 1'b0},
        {32'd512,  8'd5,   2'd0, 8'd50, 1'b0, 1'b1}
    };

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit to;
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(!blk_ready && !blk_valid && !busy && !tbl_rd_en && !sto_req && cur_disk == 0,
              "R1", "reset outputs", {blk_ready, blk_valid, busy, tbl_rd_en, sto_req}, 0);

        // R11: bases with high bits set are masked to 29 bits
        cfg(0, 1, 32'hE000_0000, 32'hE000_1000);
        cfg(2, 1, 32'h0000_0400, 32'h0000_1000);

        // Vector walk: R2 R5 R6 R7 R9 R13
        for (int v = 0; v < 6; v++) begin
            logic [31:0] st_o; int sz, md, trk, idx, nsec, first, ne;
            logic [31:0] e_lba [64]; int e_cnt [64]; logic [31:0] e_buf [64];
            logic hd, sb, wr;
            st_o = VEC[v][51:20]; sz = int'(VEC[v][19:12]); md = int'(VEC[v][11:10]);
            trk = int'(VEC[v][9:2]); hd = VEC[v][1]; sb = VEC[v][0]; wr = (v == 5);
            idx = (trk << 2) | (int'(hd) << 1) | int'(sb);
            mem[idx] = be(st_o);
            for (int j = 0; j < 64; j++) mem[1024 + j] = be(ent_val(j, md));
            first = int'(st_o >> 9);
            nsec  = int'((st_o + 32'((sz + 1) * 85) - 1) >> 9) - first + 1;
            ne = 0;
            for (int i = 0; i < nsec; i++) begin
                logic [31:0] e; e = ent_val(first + i, md);
                if (i > 0 && e == e_lba[ne-1] + 32'(e_cnt[ne-1])) e_cnt[ne-1]++;
                else begin
                    e_lba[ne] = e; e_cnt[ne] = 1;
                    e_buf[ne] = (ne == 0) ? req_buf_addr : e_buf[ne-1] + 32'(e_cnt[ne-1] * 512);
                    ne++;
                end
            end
            do_req(trk, hd, sb, sz, wr, 0, to);
            check(first_taddr == 32'(idx * 4), "R2", "offset read addr (R11 mask)", first_taddr, idx * 4);
            check(blk_valid, "R9", "valid after success", blk_valid, 1);
            check(sub_offset == 9'(st_o), "R6", "sub_offset", sub_offset, st_o % 512);
            check(ntr == 1 + nsec, "R6", "table reads", ntr, 1 + nsec);
            check(nb == ne, "R7", "burst count", nb, ne);
            for (int b = 0; b < ne && b < nb; b++) begin
                check(lg_lba[b] == e_lba[b], "R5", "burst lba", lg_lba[b], e_lba[b]);
                check(lg_cnt[b] == e_cnt[b], "R7", "burst len", lg_cnt[b], e_cnt[b]);
                check(lg_buf[b] == e_buf[b], "R7", "burst buf", lg_buf[b], e_buf[b]);
                check(lg_wr[b] == wr, "R13", "burst dir", lg_wr[b], wr);
            end
        end

        // R10: ready drops the cycle after acceptance
        mem[12] = be(32'd0);
        @(negedge clk);
        req_track = 3; req_head = 0; req_start_blk = 0; req_sec_size = 0; req_valid = 1;
        @(negedge clk); req_valid = 0;
        check(!blk_ready, "R10", "ready cleared", blk_ready, 0);
        for (int t = 0; t < 500 && !blk_ready; t++) @(negedge clk);

        // R4: offset word absent
        mem[240] = 32'hFFFF_FFFF;
        do_req(60, 0, 0, 0, 0, 0, to);
        check(blk_ready && !blk_valid && nb == 0, "R4", "absent offset", {blk_valid, 8'(nb)}, 0);

        // R8: storage error on the second burst aborts the rest
        for (int j = 0; j < 64; j++) mem[1024 + j] = be(ent_val(j, 1));
        err_at = 1;
        do_req(10, 1, 0, 191, 0, 0, to);
        err_at = -1;
        check(blk_ready && !blk_valid, "R8", "error result", blk_valid, 0);
        check(nb == 2, "R8", "bursts before abort", nb, 2);

        // R12: next_disk skips empty slots and wraps
        pulse_next();
        check(cur_disk == 2, "R12", "skip empty slot", cur_disk, 2);
        pulse_next();
        check(cur_disk == 0, "R12", "wrap to slot 0", cur_disk, 0);

        // R12: request together with next_disk uses the old slot
        do_req(3, 0, 1, 231, 0, 1, to);
        check(first_taddr == 32'd52, "R12", "old slot base", first_taddr, 52);
        check(cur_disk == 2, "R12", "slot moved", cur_disk, 2);
        pulse_next();

        // R3: empty current slot, R12: no other disk keeps slot
        cfg(2, 0, 0, 0);
        cfg(0, 0, 0, 0);
        pulse_next();
        check(cur_disk == 0, "R12", "no disk stays", cur_disk, 0);
        do_req(3, 0, 1, 0, 0, 0, to);
        check(blk_ready && !blk_valid && ntr == 0 && nb == 0, "R3", "empty slot",
              {blk_valid, 8'(ntr), 8'(nb)}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule